// File: doc/BRIEF.md
# Double-Buffered Gate-Control List Scheduler

This block drives the eight transmit priority gates of one switch port from a list of timed gate commands. Each command names a set of open gates and says how much transmitted data they stay open for. The amount is counted in transmit ticks, one per byte at gigabit rate or one per nibble at lower rates. An external periodic time base marks the start of every cycle. On each cycle start the scheduler restarts the list from its first entry. A command with a zero count ends the list, and its gate set then stays applied until the next cycle start, so untimed traffic can use the rest of the cycle.

The command store holds two halves of 64 words. Software fills the idle half and then points the buffer-select bit at it. The scheduler adopts the new half only at the next cycle start, and the active-half output lets software see when the swap has happened. Two sticky error flags report a list that outlasted its cycle and a list that ran off the end of its half.

Top module: `gate_list_sched`

## Requirements
- R1: A write with `wr_sel`=1 stores `wr_data[21:0]` at command address `wr_addr`. Address bit 6 selects the half and bits 5:0 select the entry. In a command word, bits 21:8 are the tick count and bits 7:0 are the gate mask, with bit n opening priority n. A write with `wr_sel`=0 loads the control word: bit0 is the global enable, bit1 the port enable, bit2 the buffer select, bit3 single-half mode and bit4 clear-errors.
- R2: While either enable bit is clear, `gate_open` is all ones and cycle starts are ignored. After both enables are set, the gates stay all open until the first cycle start.
- R3: A cycle start loads entry 0 of the half that becomes active, and its mask appears on `gate_open` after that clock edge.
- R4: A command with count C > 0 keeps its mask for exactly C transmit ticks. The following entry is then applied.
- R5: A command with count 0 ends the list. Its mask stays on `gate_open` through any number of ticks until the next cycle start.
- R6: `act_half` takes the buffer-select value only at a cycle start. It never changes in the middle of a cycle.
- R7: In single-half mode the buffer select is ignored and the active half does not change at a cycle start.
- R8: A cycle start that arrives while a timed command is still counting sets the sticky `cnt_err` and restarts the list. A cycle start that arrives after a terminating command does not set it.
- R9: If the tick count of entry 63 runs out without a terminating command, the scheduler sets the sticky `addr_err` and keeps entry 63's mask until the next cycle start.
- R10: Both error flags stay set, even while the scheduler is disabled, until a control write with bit4 set clears them.
- R11: When a cycle start and a tick come in the same cycle, the cycle start wins and the tick is not counted against entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 1 selects the command store, 0 selects the control word |
| wr_addr | input | 7 | Command address: half in bit 6, entry in bits 5:0 |
| wr_data | input | 32 | Write data |
| cyc_start | input | 1 | One-cycle pulse from the time base at each cycle start |
| tx_tick | input | 1 | One pulse per transmitted byte or nibble |
| gate_open | output | 8 | Gate mask applied to the eight priorities |
| act_half | output | 1 | Half of the command store currently in use |
| cnt_err | output | 1 | Sticky flag: the list outlasted its cycle |
| addr_err | output | 1 | Sticky flag: the list ran past the last entry |

## Verification
The bench checks a tick that coincides with a cycle start. A design that let the tick count would cut entry 0 short and move to entry 1 one tick early. The buffer select is changed in the middle of a cycle. An eager design would swap halves at once and show the new list's mask before the cycle boundary. The bench fills a whole half with timed commands so the list runs past entry 63. A design that wrapped the index would return to entry 0 instead of flagging the error and holding the last mask. The bench also checks that a cycle start after a terminating command leaves `cnt_err` clear, and that disabling the block opens every gate and makes it ignore cycle starts.

// File: rtl/gate_list_sched.sv
module gate_list_sched #(
  parameter int GATES   = 8,
  parameter int CNT_W   = 14,
  parameter int IDX_W   = 6,
  parameter int CNT_LSB = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W:0]    wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_start,
  input  logic              tx_tick,
  output logic [GATES-1:0]  gate_open,
  output logic              act_half,
  output logic              cnt_err,
  output logic              addr_err
);
  localparam int HALF   = 1 << IDX_W;
  localparam int DEPTH  = 2 * HALF;
  localparam int WORD_W = CNT_LSB + CNT_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  logic [WORD_W-1:0] ram [DEPTH];
  logic              en_g, en_p, sel, one_half;
  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  rem;
  logic [GATES-1:0]  mask;

  wire run     = en_g & en_p;
  wire ctl_wr  = wr_en & ~wr_sel;
  wire clr     = ctl_wr & wr_data[4];
  wire new_half = one_half ? act_half : sel;

  wire [IDX_W-1:0]  idx_nxt  = idx + IDX_W'(1);
  wire [WORD_W-1:0] head     = ram[{new_half, {IDX_W{1'b0}}}];
  wire [WORD_W-1:0] nxt      = ram[{act_half, idx_nxt}];
  wire [CNT_W-1:0]  head_cnt = head[CNT_LSB +: CNT_W];
  wire [CNT_W-1:0]  nxt_cnt  = nxt[CNT_LSB +: CNT_W];

  assign gate_open = (st == S_IDLE) ? {GATES{1'b1}} : mask;

  always_ff @(posedge clk)
    if (wr_en && wr_sel) ram[wr_addr] <= wr_data[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_g <= 1'b0; en_p <= 1'b0; sel <= 1'b0; one_half <= 1'b0;
    end else if (ctl_wr) begin
      en_g <= wr_data[0]; en_p <= wr_data[1];
      sel  <= wr_data[2]; one_half <= wr_data[3];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; rem <= '0; mask <= '0;
      act_half <= 1'b0; cnt_err <= 1'b0; addr_err <= 1'b0;
    end else begin
      if (clr) begin
        cnt_err  <= 1'b0;
        addr_err <= 1'b0;
      end
      if (!run) begin
        st  <= S_IDLE;
        idx <= '0;
        rem <= '0;
      end else if (cyc_start) begin
        if (st == S_RUN) cnt_err <= 1'b1;
        act_half <= new_half;
        idx      <= '0;
        mask     <= head[GATES-1:0];
        rem      <= head_cnt;
        st       <= (head_cnt == '0) ? S_HOLD : S_RUN;
      end else if (tx_tick && st == S_RUN) begin
        if (rem != CNT_W'(1)) begin
          rem <= rem - CNT_W'(1);
        end else if (idx == LAST) begin
          addr_err <= 1'b1;
          rem      <= '0;
          st       <= S_HOLD;
        end else begin
          idx  <= idx_nxt;
          mask <= nxt[GATES-1:0];
          rem  <= nxt_cnt;
          st   <= (nxt_cnt == '0) ? S_HOLD : S_RUN;
        end
      end
    end
endmodule

// File: rtl/gate_list_sched_chk.sv
module gate_list_sched_chk #(
  parameter int GATES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             tx_tick,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             clr_bit,
  input logic             run,
  input logic [GATES-1:0] gate_open,
  input logic             act_half,
  input logic             cnt_err,
  input logic             addr_err
);
  // R2
  disabled_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> gate_open == {GATES{1'b1}});

  // R6
  half_swap_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_half) |-> $past(cyc_start));

  // R8
  cnt_err_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_err) |-> $past(cyc_start));

  // R9
  addr_err_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |-> $past(tx_tick));

  // R10
  cnt_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_err) |-> $past(wr_en && !wr_sel && clr_bit));

  // R10
  addr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_err) |-> $past(wr_en && !wr_sel && clr_bit));

  // R5
  gate_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_open) |-> ($past(cyc_start) || $past(tx_tick) || !$past(run)));
endmodule

bind gate_list_sched gate_list_sched_chk #(.GATES(GATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .tx_tick(tx_tick),
  .wr_en(wr_en), .wr_sel(wr_sel), .clr_bit(wr_data[4]), .run(run),
  .gate_open(gate_open), .act_half(act_half), .cnt_err(cnt_err), .addr_err(addr_err)
);

// File: tb/gate_list_sched_bench.sv
`timescale 1ns/1ps
module gate_list_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cyc_start = 1'b0, tx_tick = 1'b0;
  logic [7:0]  gate_open;
  logic        act_half, cnt_err, addr_err;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN = 32'h3, SEL = 32'h4, ONE = 32'h8, CLR = 32'h10;

  // {cyc_start, tx_tick, expected gate mask, expected cnt_err}
  localparam logic [10:0] VEC [15] = '{
    {1'b1, 1'b0, 8'h01, 1'b0}, {1'b0, 1'b1, 8'h01, 1'b0},
    {1'b0, 1'b1, 8'h02, 1'b0}, {1'b0, 1'b1, 8'h02, 1'b0},
    {1'b0, 1'b0, 8'h02, 1'b0}, {1'b0, 1'b1, 8'h02, 1'b0},
    {1'b0, 1'b1, 8'h0C, 1'b0}, {1'b0, 1'b1, 8'h0C, 1'b0},
    {1'b0, 1'b1, 8'h0C, 1'b0}, {1'b1, 1'b0, 8'h01, 1'b0},
    {1'b0, 1'b1, 8'h01, 1'b0}, {1'b1, 1'b0, 8'h01, 1'b1},
    {1'b1, 1'b1, 8'h01, 1'b1}, {1'b0, 1'b1, 8'h01, 1'b1},
    {1'b0, 1'b1, 8'h02, 1'b1}
  };

  gate_list_sched u_gate_list_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .cyc_start(cyc_start), .tx_tick(tx_tick),
    .gate_open(gate_open), .act_half(act_half), .cnt_err(cnt_err), .addr_err(addr_err)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_gate(input string req, input logic [7:0] exp);
    check(gate_open === exp, req, int'(gate_open), int'(exp));
  endtask

  task automatic wr(input logic s, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic cs, input logic tk);
    @(negedge clk);
    cyc_start = cs; tx_tick = tk;
    @(negedge clk);
    cyc_start = 1'b0; tx_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk_gate("R2 reset gates", 8'hFF);
    check(!cnt_err && !addr_err && !act_half, "R10 reset flags",
          int'({act_half, cnt_err, addr_err}), 0);
    rst_n = 1'b1;
    idle(1);

    wr(1'b1, 7'd0, (32'd2 << 8) | 32'h01);
    wr(1'b1, 7'd1, (32'd3 << 8) | 32'h02);
    wr(1'b1, 7'd2, (32'd0 << 8) | 32'h0C);

    wr(1'b0, 7'd0, 32'h1);
    idle(2);
    step(1'b1, 1'b0);
    chk_gate("R2 port enable needed", 8'hFF);

    wr(1'b0, 7'd0, EN);
    idle(2);
    chk_gate("R2 open before first start", 8'hFF);

    // R3 R4 R5 R8 R11
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][10], VEC[i][9]);
      chk_gate($sformatf("R4 vector %0d gate", i), VEC[i][8:1]);
      check(cnt_err === VEC[i][0], $sformatf("R8 vector %0d cnt_err", i),
            int'(cnt_err), int'(VEC[i][0]));
    end

    wr(1'b0, 7'd0, EN | CLR);
    idle(1);
    check(cnt_err === 1'b0, "R10 clear cnt_err", int'(cnt_err), 0);

    wr(1'b1, 7'd64, (32'd1 << 8) | 32'h40);
    wr(1'b1, 7'd65, (32'd0 << 8) | 32'h80);
    wr(1'b0, 7'd0, EN | SEL);
    idle(1);
    check(act_half === 1'b0, "R6 no swap mid-cycle", int'(act_half), 0);
    step(1'b0, 1'b1);
    chk_gate("R6 old list still running", 8'h02);
    step(1'b1, 1'b0);
    check(act_half === 1'b1, "R6 swap at cycle start", int'(act_half), 1);
    chk_gate("R3 new half entry 0", 8'h40);
    step(1'b0, 1'b1);
    chk_gate("R4 count one advances", 8'h80);
    step(1'b0, 1'b1);
    chk_gate("R5 terminal held", 8'h80);

    wr(1'b0, 7'd0, EN | ONE);
    step(1'b1, 1'b0);
    check(act_half === 1'b1, "R7 single half keeps half", int'(act_half), 1);
    chk_gate("R7 single half list", 8'h40);
    wr(1'b0, 7'd0, EN);
    step(1'b1, 1'b0);
    check(act_half === 1'b0, "R6 back to half 0", int'(act_half), 0);
    chk_gate("R1 half 0 entry 0", 8'h01);

    for (int i = 0; i < 64; i++)
      wr(1'b1, 7'(i), (32'd1 << 8) | 32'(i));
    step(1'b1, 1'b0);
    wr(1'b0, 7'd0, EN | CLR);
    chk_gate("R3 full list entry 0", 8'h00);
    for (int i = 0; i < 63; i++) step(1'b0, 1'b1);
    chk_gate("R4 entry 63 reached", 8'h3F);
    check(addr_err === 1'b0, "R9 no early addr_err", int'(addr_err), 0);
    step(1'b0, 1'b1);
    check(addr_err === 1'b1, "R9 addr_err set", int'(addr_err), 1);
    chk_gate("R9 last mask held", 8'h3F);
    step(1'b0, 1'b1);
    chk_gate("R9 still held", 8'h3F);
    step(1'b1, 1'b0);
    chk_gate("R9 restart on cycle start", 8'h00);
    check(addr_err === 1'b1, "R10 addr_err sticky", int'(addr_err), 1);
    check(cnt_err === 1'b0, "R8 no cnt_err after hold", int'(cnt_err), 0);

    wr(1'b0, 7'd0, 32'h0);
    idle(1);
    chk_gate("R2 disable opens gates", 8'hFF);
    step(1'b1, 1'b0);
    chk_gate("R2 start ignored when off", 8'hFF);
    check(addr_err === 1'b1, "R10 flag kept while off", int'(addr_err), 1);

    wr(1'b1, 7'd64, (32'd0 << 8) | 32'h55);
    wr(1'b0, 7'd0, EN | SEL);
    idle(1);
    chk_gate("R2 waits for start", 8'hFF);
    step(1'b1, 1'b0);
    chk_gate("R5 zero head", 8'h55);
    check(act_half === 1'b1, "R6 swap to half 1", int'(act_half), 1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    chk_gate("R5 zero head held", 8'h55);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule